// File: doc/BRIEF.md
# Diagnostic DAC Output Selector

This block produces the 8-bit code for a diagnostic DAC from a multi-channel pulse-processing pipeline. Each channel offers four internal observation points. A per-channel multiplexer turns the chosen one into a 16-bit diagnostic word. The four points are:
- an early raw sample tap;
- a mid-pipeline raw sample tap;
- the filtered baseline value, zero-extended;
- a word that carries only the baseline-tracker activity flag.

A second stage picks one channel's word and takes an 8-bit slice of it at a programmable LSB position. Moving that position works as a coarse gain control on the scope trace.

Two small registers on a simple write port hold the selection, and both reset to zero. The DAC code is registered. It follows the taps with one clock of latency, and a selection write is reflected one clock after the edge that stores it. A build parameter set to 0 ties the DAC code to zero and removes all selection logic.

Top module: `diag_dac_sel`

## Requirements
- R1: After reset both selection registers are zero. The DAC code is zero while reset is asserted. Once reset is released, the output shows bits 7:0 of channel 0's early tap.
- R2: A write to address 0x400 stores the channel number from wdata bits 3:0.
- R3: A write to address 0x400 stores the window LSB index from wdata bits 7:4. The DAC code equals word[idx+7:idx] of the selected channel's 16-bit word, so index 4 gives bits 11:4.
- R4: A window index above 8 behaves as index 8, which gives bits 15:8.
- R5: A channel number equal to or above NUM_CH gives a DAC code of zero.
- R6: A write to address 0x410 stores the source from wdata bits 1:0. Source 0 selects the early raw tap.
- R7: Source 1 gives a word whose bit 8 is the tracking flag and whose other bits are all zero.
- R8: Source 2 selects the mid-pipeline raw tap.
- R9: Source 3 selects the 14-bit baseline, zero-extended into bits 13:0.
- R10: The DAC code is the registered function of the taps and the selection registers as they stood before the clock edge, which is one clock of latency.
- R11: Writes to any other address leave both registers unchanged. With we low, nothing is stored.
- R12: With DIAG_EN = 0, the DAC code is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register write address |
| cfg_wdata_i | input | 8 | Register write data |
| early_tap_i | input | NUM_CH*WORD_W | Early raw sample per channel |
| mid_tap_i | input | NUM_CH*WORD_W | Mid-pipeline raw sample per channel |
| trk_flag_i | input | NUM_CH | Baseline-tracking-active flag per channel |
| baseline_i | input | NUM_CH*BL_W | Filtered baseline per channel |
| dac_code_o | output | DAC_W | Registered DAC code |

## Verification
The hardest situations to reach are the ones where a register write and a tap change meet at the same clock edge. The output must then use the old selection with the new taps, and the new selection must appear only one clock later. The stimulus randomizes taps every cycle and interleaves random writes to both registers and to foreign addresses. Directed sequences cover these cases:
- window indices 9 to 15;
- channel numbers at and above NUM_CH;
- the flag source with the flag toggling, which places the flag under every window position.

// File: rtl/diag_dac_pkg.sv
`timescale 1ns/1ps
package diag_dac_pkg;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned FLAG_BIT = 8;

  typedef enum logic [1:0] {
    SRC_EARLY = 2'd0,
    SRC_FLAG  = 2'd1,
    SRC_MID   = 2'd2,
    SRC_BASE  = 2'd3
  } diag_src_e;
endpackage

// File: rtl/diag_cfg_regs.sv
`timescale 1ns/1ps
module diag_cfg_regs
  import diag_dac_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h400,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 12'h410
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [SEL_W-1:0]  ch_sel_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output diag_src_e         src_o
);
  logic hit_sel, hit_src;
  assign hit_sel = we_i && (addr_i == SEL_ADDR);
  assign hit_src = we_i && (addr_i == SRC_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_sel_o  <= '0;
      win_idx_o <= '0;
    end else if (hit_sel) begin
      ch_sel_o  <= wdata_i[SEL_W-1:0];
      win_idx_o <= wdata_i[SEL_W +: IDX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      src_o <= SRC_EARLY;
    else if (hit_src) src_o <= diag_src_e'(wdata_i[1:0]);
  end
endmodule

// File: rtl/diag_ch_mux.sv
`timescale 1ns/1ps
module diag_ch_mux
  import diag_dac_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BL_W   = 14
) (
  input  logic [WORD_W-1:0] early_i,
  input  logic [WORD_W-1:0] mid_i,
  input  logic              flag_i,
  input  logic [BL_W-1:0]   base_i,
  input  diag_src_e         src_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    unique case (src_i)
      SRC_EARLY: word_o = early_i;
      SRC_FLAG:  word_o[FLAG_BIT] = flag_i;
      SRC_MID:   word_o = mid_i;
      SRC_BASE:  word_o[BL_W-1:0] = base_i;
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/diag_win_sel.sv
`timescale 1ns/1ps
module diag_win_sel
  import diag_dac_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DAC_W  = 8
) (
  input  logic [WORD_W-1:0] words_i [NUM_CH],
  input  logic [SEL_W-1:0]  ch_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [IDX_W-1:0]  eff_idx_o,
  output logic [DAC_W-1:0]  code_o
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(WORD_W - DAC_W);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] shifted;

  // out-of-range channel matches no iteration and leaves zero
  always_comb begin
    word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_i == SEL_W'(c)) word = words_i[c];
    end
  end

  assign eff_idx_o = (idx_i > MAX_IDX) ? MAX_IDX : idx_i;
  assign shifted   = word >> eff_idx_o;
  assign code_o    = shifted[DAC_W-1:0];
endmodule

// File: rtl/diag_dac_sel.sv
`timescale 1ns/1ps
module diag_dac_sel
  import diag_dac_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned DAC_W   = 8,
  parameter int unsigned BL_W    = 14,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h400,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 12'h410,
  parameter bit          DIAG_EN = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [ADDR_W-1:0]        cfg_addr_i,
  input  logic [7:0]               cfg_wdata_i,
  input  logic [NUM_CH*WORD_W-1:0] early_tap_i,
  input  logic [NUM_CH*WORD_W-1:0] mid_tap_i,
  input  logic [NUM_CH-1:0]        trk_flag_i,
  input  logic [NUM_CH*BL_W-1:0]   baseline_i,
  output logic [DAC_W-1:0]         dac_code_o
);
  localparam logic [SEL_W:0] NCH_L = (SEL_W+1)'(NUM_CH);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(WORD_W - DAC_W);

  if (DIAG_EN) begin : g_on
    logic [SEL_W-1:0]  ch_sel;
    logic [IDX_W-1:0]  win_idx, eff_idx;
    diag_src_e         src;
    logic [WORD_W-1:0] ch_word [NUM_CH];
    logic [DAC_W-1:0]  code_d;
    logic [DAC_W-1:0]  code_q;

    diag_cfg_regs #(
      .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .SRC_ADDR(SRC_ADDR)
    ) i_cfg (
      .clk_i, .rst_ni,
      .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
      .ch_sel_o(ch_sel), .win_idx_o(win_idx), .src_o(src)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      diag_ch_mux #(.WORD_W(WORD_W), .BL_W(BL_W)) i_mux (
        .early_i(early_tap_i[c*WORD_W +: WORD_W]),
        .mid_i  (mid_tap_i[c*WORD_W +: WORD_W]),
        .flag_i (trk_flag_i[c]),
        .base_i (baseline_i[c*BL_W +: BL_W]),
        .src_i  (src),
        .word_o (ch_word[c])
      );

      p_flag_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src == SRC_FLAG) |-> ((ch_word[c] & ~(WORD_W'(1) << FLAG_BIT)) == '0));
      p_base_zext_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src == SRC_BASE) |-> (ch_word[c][WORD_W-1:BL_W] == '0));
    end

    diag_win_sel #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .DAC_W(DAC_W)) i_win (
      .words_i(ch_word), .ch_i(ch_sel), .idx_i(win_idx),
      .eff_idx_o(eff_idx), .code_o(code_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q <= '0;
      else         code_q <= code_d;
    end
    assign dac_code_o = code_q;

    p_reset_zero_r1: assert property (@(posedge clk_i)
      !rst_ni |-> (dac_code_o == '0));
    p_idx_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_idx > MAX_IDX) |-> (eff_idx == MAX_IDX));
    p_bad_ch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, ch_sel} >= NCH_L) |=> (dac_code_o == '0));
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(code_d)) |=> $stable(dac_code_o));
    p_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_we_i || (cfg_addr_i != SEL_ADDR && cfg_addr_i != SRC_ADDR))
      |=> ($stable(ch_sel) && $stable(win_idx) && $stable(src)));
  end else begin : g_off
    assign dac_code_o = '0;
  end
endmodule

// File: tb/test_diag_dac_sel.sv
`timescale 1ns/1ps
module test_diag_dac_sel;
  localparam int NUM_CH = 4;
  localparam int WORD_W = 16;
  localparam int BL_W   = 14;
  localparam logic [11:0] A_SEL = 12'h400;
  localparam logic [11:0] A_SRC = 12'h410;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0;
  logic [11:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [NUM_CH*WORD_W-1:0] early = '0, mid = '0;
  logic [NUM_CH-1:0] flag = '0;
  logic [NUM_CH*BL_W-1:0] base = '0;
  logic [7:0] dac, dac_off;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int sh_ch = 0, sh_idx = 0, sh_src = 0;

  always #2 clk = ~clk;

  diag_dac_sel i_diag_dac_sel (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .early_tap_i(early), .mid_tap_i(mid),
    .trk_flag_i(flag), .baseline_i(base), .dac_code_o(dac)
  );
  diag_dac_sel #(.DIAG_EN(1'b0)) i_diag_dac_sel_off (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .early_tap_i(early), .mid_tap_i(mid),
    .trk_flag_i(flag), .baseline_i(base), .dac_code_o(dac_off)
  );

  function automatic logic [7:0] model(int ch, int idx, int src);
    logic [15:0] w;
    int e;
    if (ch >= NUM_CH) return 8'h00;
    case (src)
      0: w = early[ch*WORD_W +: WORD_W];
      1: w = {7'd0, flag[ch], 8'd0};
      2: w = mid[ch*WORD_W +: WORD_W];
      default: w = {2'b00, base[ch*BL_W +: BL_W]};
    endcase
    e = (idx > 8) ? 8 : idx;
    return 8'((w >> e) & 16'h00ff);
  endfunction

  function automatic string tag_of(int ch, int idx, int src);
    if (ch >= NUM_CH) return "R5";
    if (idx > 8) return "R4";
    case (src)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dac actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rand_taps();
    for (int c = 0; c < NUM_CH; c++) begin
      early[c*WORD_W +: WORD_W] = 16'($urandom);
      mid[c*WORD_W +: WORD_W]   = 16'($urandom);
      base[c*BL_W +: BL_W]      = 14'($urandom);
    end
    flag = NUM_CH'($urandom);
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic step(bit we, logic [11:0] a, logic [7:0] d, string tag);
    logic [7:0] exp;
    string t;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    rand_taps();
    exp = model(sh_ch, sh_idx, sh_src);
    t = (tag == "") ? tag_of(sh_ch, sh_idx, sh_src) : tag;
    @(posedge clk);
    if (we && a == A_SEL) begin sh_ch = int'(d[3:0]); sh_idx = int'(d[7:4]); end
    if (we && a == A_SRC) sh_src = int'(d[1:0]);
    @(negedge clk);
    cfg_we = 0;
    check(t, dac, exp);
    check("R12", dac_off, 8'h00);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rand_taps();
    repeat (3) @(negedge clk);
    check("R1", dac, 8'h00);
    check("R12", dac_off, 8'h00);
    rst_ni = 1;
    // R1: reset selection is ch0, index 0, early tap
    step(0, 12'h0, 8'h0, "R1");
    // R2/R3: channel 2, index 4 -> bits 11:4
    step(1, A_SEL, 8'h42, "R1");
    step(0, 12'h0, 8'h0, "R3");
    step(1, A_SEL, 8'h03, "R2");
    step(0, 12'h0, 8'h0, "R2");
    // R4: indices 9..15
    for (int i = 9; i < 16; i++) begin
      step(1, A_SEL, 8'((i << 4) | 1), "");
      step(0, 12'h0, 8'h0, "R4");
    end
    // R5: out-of-range channels
    for (int c = NUM_CH; c < 16; c++) begin
      step(1, A_SEL, 8'(c), "");
      step(0, 12'h0, 8'h0, "R5");
    end
    // R7: flag under every window position
    step(1, A_SRC, 8'h01, "");
    for (int i = 0; i < 16; i++) begin
      step(1, A_SEL, 8'((i << 4) | (i % NUM_CH)), "");
      step(0, 12'h0, 8'h0, "R7");
    end
    // R9/R8/R6 directed
    step(1, A_SRC, 8'h03, "");
    step(1, A_SEL, 8'h60, "R9");
    step(0, 12'h0, 8'h0, "R9");
    step(1, A_SRC, 8'h02, "R9");
    step(0, 12'h0, 8'h0, "R8");
    step(1, A_SRC, 8'hFC, "R8");
    step(0, 12'h0, 8'h0, "R6");
    // R11: foreign addresses and we low leave the selection unchanged
    step(1, 12'h404, 8'h3F, "R11");
    step(1, 12'h000, 8'hF1, "R11");
    step(0, A_SEL, 8'hF3, "R11");
    step(0, A_SRC, 8'h02, "R11");
    step(0, 12'h0, 8'h0, "R11");
    // R10: write and tap change on the same edge, random mix
    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom % 8);
      logic [11:0] a = (k < 2) ? A_SEL : (k < 4) ? A_SRC : (k == 4) ? 12'($urandom) : A_SEL;
      bit we = (k != 7) && ($urandom % 3 == 0);
      step(we, a, 8'($urandom), (n % 5 == 0) ? "R10" : "");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule